// File: doc/BRIEF.md
# Output-Compare Timer with Interrupt Masking

This block is a timer built around a 16-bit counter that runs freely from reset. Five compare channels each hold a 16-bit target value. When the counter reaches a channel's target, that channel's event flag is set. Channels two to five can also change a dedicated output pin, and a 2-bit action code per channel selects what happens to that pin. Three capture inputs record the counter value on a rising edge. A fifth slot is shared: it works either as compare channel five or as capture channel four, depending on a configuration bit.

An 8-bit flag register and an 8-bit mask register use the same bit layout. The block raises one interrupt line whenever any flag is set together with its matching enable bit. Software reaches every register over a small word-wide bus. Writes take effect on the clock edge, and reads are combinational from the address. Flags are cleared by writing ones to them.

Top module: `octmr`

## Requirements
- R1: After reset the counter starts at 0, rises by one on every clock edge and wraps from 16'hFFFF to 0. It is readable at address 0, and writes to that address are ignored.
- R2: On the edge where the counter equals a compare register, the channel's flag is set whether or not its enable bit is set. Flag bit 7 belongs to compare 1, bit 6 to compare 2, bit 5 to compare 3 and bit 4 to compare 4.
- R3: On a match, the 2-bit action code changes the channel's pin: 00 leaves it unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. Each pair in the action register has its mode bit as the higher bit. Bits [7:6] belong to channel 2, [5:4] to channel 3, [3:2] to channel 4 and [1:0] to channel 5. cmpPin bit 0 is channel 2 and bit 3 is channel 5.
- R4: When config bit 0 is 0, the shared slot is compare 5: it drives cmpPin[3] and sets flag bit 3 on a match. When config bit 0 is 1, the slot is capture 4 on capIn[3]: a compare-5 match then sets no flag and leaves cmpPin[3] unchanged. A capIn[3] edge while the bit is 0 has no effect.
- R5: A rising edge on capIn[k] latches the counter value of that clock into capture register k and sets the channel's flag. capIn[0], [1] and [2] map to flag bits 2, 1 and 0, and capIn[3] maps to bit 3 when the slot is in capture mode. Capture registers are read-only.
- R6: The mask register uses the same bit layout as the flag register. Setting an enable bit never changes the flags.
- R7: Writing the flag address clears each flag whose written bit is 1 and leaves the others unchanged. If a clear and a new event hit the same bit on the same edge, the bit ends up set.
- R8: irq is high exactly while some flag bit and its mask bit are both 1. It drops once the flag is cleared or the enable is removed.
- R9: Reset sets the counter, captures, action, mask, flags, config and pins to 0, and every compare register to 16'hFFFF.
- R10: Register addresses are: 0 counter, 1 to 5 compare 1 to 5, 6 to 9 capture 1 to 4, 10 action, 11 mask, 12 flags, 13 config. Unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register address |
| busWe | input | 1 | Write strobe, acts on the rising clock edge |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data for busAddr |
| capIn | input | 4 | Capture inputs; bit 3 is the shared slot |
| cmpPin | output | 4 | Compare pins for channels 2 to 5 |
| irq | output | 1 | Interrupt request |

## Verification
A match or capture edge is registered on the edge where it occurs, so the flag, pin and irq changes become visible one edge later. A captured value equals the counter value that the capture edge registered. A register write is visible from the next edge on, and read data follows busAddr with no delay. The bench drives inputs just after the rising edge. It updates a behavioural model on that same edge and compares read data, pins and irq against the model at every falling edge, so each result is sampled in the cycle it is due.

// File: rtl/octmr_pkg.sv
package octmr_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_OC  = 5;
  localparam int NUM_IC  = 4;
  localparam int NUM_PIN = NUM_OC - 1;
  localparam int FLG_W   = NUM_OC + NUM_IC - 1;
  localparam int ADDR_W  = 4;

  localparam int A_CNT = 0;
  localparam int A_CMP = 1;
  localparam int A_CAP = A_CMP + NUM_OC;
  localparam int A_ACT = A_CAP + NUM_IC;
  localparam int A_MSK = A_ACT + 1;
  localparam int A_FLG = A_MSK + 1;
  localparam int A_CFG = A_FLG + 1;

  typedef struct packed {
    logic [NUM_OC-1:0] cmpWr;
    logic [CNT_W-1:0]  wdata;
    logic              slotCapture;
  } dpStrobe_t;

  // compares 1..4 fill the top bits, shared slot next, captures 1..3 last
  function automatic logic [FLG_W-1:0] packFlags(input logic [NUM_OC-1:0] oc,
                                                 input logic [NUM_IC-1:0] ic);
    logic [FLG_W-1:0] f;
    f = '0;
    for (int i = 0; i < NUM_OC-1; i++) f[FLG_W-1-i] = oc[i];
    f[NUM_IC-1] = oc[NUM_OC-1] | ic[NUM_IC-1];
    for (int k = 0; k < NUM_IC-1; k++) f[NUM_IC-2-k] = ic[k];
    return f;
  endfunction
endpackage

// File: rtl/octmr_datapath.sv
module octmr_datapath
  import octmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [NUM_IC-1:0] capIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  cntQ,
  output logic [NUM_OC-1:0] ocMatch,
  output logic [NUM_IC-1:0] capEvt,
  output logic [CNT_W-1:0]  dpRdata
);
  logic [NUM_OC-1:0][CNT_W-1:0] cmpArr;
  logic [NUM_IC-1:0][CNT_W-1:0] capArr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntQ + CNT_W'(1);
  end

  for (genvar i = 0; i < NUM_OC; i++) begin : g_cmp
    logic [CNT_W-1:0] cmpR;
    logic             hit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cmpR <= '1;
      else if (strb.cmpWr[i]) cmpR <= strb.wdata;
    end
    assign hit       = (cntQ == cmpR);
    assign cmpArr[i] = cmpR;
    if (i == NUM_OC-1) begin : g_shared
      assign ocMatch[i] = hit & ~strb.slotCapture;
    end else begin : g_plain
      assign ocMatch[i] = hit;
    end
  end

  for (genvar k = 0; k < NUM_IC; k++) begin : g_cap
    logic             prevIn;
    logic             edgeHit;
    logic [CNT_W-1:0] capR;
    assign edgeHit = capIn[k] & ~prevIn;
    if (k == NUM_IC-1) begin : g_shared
      assign capEvt[k] = edgeHit & strb.slotCapture;
    end else begin : g_plain
      assign capEvt[k] = edgeHit;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevIn <= 1'b0;
        capR   <= '0;
      end else begin
        prevIn <= capIn[k];
        if (capEvt[k]) capR <= cntQ;
      end
    end
    assign capArr[k] = capR;
  end

  always_comb begin
    dpRdata = '0;
    if (rdAddr == ADDR_W'(A_CNT)) dpRdata = cntQ;
    for (int i = 0; i < NUM_OC; i++)
      if (rdAddr == ADDR_W'(A_CMP + i)) dpRdata = cmpArr[i];
    for (int k = 0; k < NUM_IC; k++)
      if (rdAddr == ADDR_W'(A_CAP + k)) dpRdata = capArr[k];
  end
endmodule

// File: rtl/octmr_ctrl.sv
module octmr_ctrl
  import octmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [CNT_W-1:0]     busWdata,
  input  logic [CNT_W-1:0]     dpRdata,
  input  logic [NUM_OC-1:0]    ocMatch,
  input  logic [NUM_IC-1:0]    capEvt,
  output dpStrobe_t            strb,
  output logic [CNT_W-1:0]     busRdata,
  output logic [NUM_PIN-1:0]   cmpPin,
  output logic                 irq,
  output logic [FLG_W-1:0]     flagQ,
  output logic [FLG_W-1:0]     maskQ,
  output logic [2*NUM_PIN-1:0] actQ,
  output logic                 selQ
);
  logic             hitAct, hitMsk, hitFlg, hitCfg;
  logic [FLG_W-1:0] clrVec, evVec;

  assign hitAct = busWe && (busAddr == ADDR_W'(A_ACT));
  assign hitMsk = busWe && (busAddr == ADDR_W'(A_MSK));
  assign hitFlg = busWe && (busAddr == ADDR_W'(A_FLG));
  assign hitCfg = busWe && (busAddr == ADDR_W'(A_CFG));

  always_comb begin
    for (int i = 0; i < NUM_OC; i++)
      strb.cmpWr[i] = busWe && (busAddr == ADDR_W'(A_CMP + i));
    strb.wdata       = busWdata;
    strb.slotCapture = selQ;
  end

  assign clrVec = hitFlg ? busWdata[FLG_W-1:0] : '0;
  assign evVec  = packFlags(ocMatch, capEvt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ  <= '0;
      maskQ <= '0;
      flagQ <= '0;
      selQ  <= 1'b0;
    end else begin
      if (hitAct) actQ  <= busWdata[2*NUM_PIN-1:0];
      if (hitMsk) maskQ <= busWdata[FLG_W-1:0];
      if (hitCfg) selQ  <= busWdata[0];
      flagQ <= (flagQ & ~clrVec) | evVec;
    end
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    logic [1:0] code;
    logic       pinQ;
    assign code = actQ[2*(NUM_PIN-1-p)+1 -: 2];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pinQ <= 1'b0;
      else if (ocMatch[p+1]) begin
        case (code)
          2'b01:   pinQ <= ~pinQ;
          2'b10:   pinQ <= 1'b0;
          2'b11:   pinQ <= 1'b1;
          default: pinQ <= pinQ;
        endcase
      end
    end
    assign cmpPin[p] = pinQ;
  end

  assign irq = |(flagQ & maskQ);

  always_comb begin
    busRdata = dpRdata;
    if (busAddr == ADDR_W'(A_ACT)) busRdata = CNT_W'(actQ);
    if (busAddr == ADDR_W'(A_MSK)) busRdata = CNT_W'(maskQ);
    if (busAddr == ADDR_W'(A_FLG)) busRdata = CNT_W'(flagQ);
    if (busAddr == ADDR_W'(A_CFG)) busRdata = CNT_W'(selQ);
  end
endmodule

// File: rtl/octmr.sv
module octmr
  import octmr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [CNT_W-1:0]   busWdata,
  output logic [CNT_W-1:0]   busRdata,
  input  logic [NUM_IC-1:0]  capIn,
  output logic [NUM_PIN-1:0] cmpPin,
  output logic               irq
);
  dpStrobe_t            strb;
  logic [CNT_W-1:0]     cntQ;
  logic [CNT_W-1:0]     dpRdata;
  logic [NUM_OC-1:0]    ocMatch;
  logic [NUM_IC-1:0]    capEvt;
  logic [FLG_W-1:0]     flagQ;
  logic [FLG_W-1:0]     maskQ;
  logic [2*NUM_PIN-1:0] actQ;
  logic                 selQ;

  octmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capIn(capIn), .rdAddr(busAddr),
    .cntQ(cntQ), .ocMatch(ocMatch), .capEvt(capEvt), .dpRdata(dpRdata)
  );

  octmr_ctrl u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .dpRdata(dpRdata), .ocMatch(ocMatch), .capEvt(capEvt), .strb(strb),
    .busRdata(busRdata), .cmpPin(cmpPin), .irq(irq), .flagQ(flagQ),
    .maskQ(maskQ), .actQ(actQ), .selQ(selQ)
  );
endmodule

// File: rtl/octmr_chk.sv
module octmr_chk
  import octmr_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [CNT_W-1:0]   busWdata,
  input logic [CNT_W-1:0]   cntQ,
  input logic [NUM_OC-1:0]  ocMatch,
  input logic [NUM_IC-1:0]  capEvt,
  input logic [FLG_W-1:0]   flagQ,
  input logic               selQ,
  input logic [NUM_PIN-1:0] cmpPin,
  input logic               irq
);
  logic [FLG_W-1:0] clrNow;
  logic             ctlWrite;
  assign clrNow   = (busWe && busAddr == ADDR_W'(A_FLG)) ? busWdata[FLG_W-1:0] : '0;
  assign ctlWrite = busWe && (busAddr == ADDR_W'(A_FLG) || busAddr == ADDR_W'(A_MSK));

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cntQ == CNT_W'($past(cntQ) + CNT_W'(1)));

  a_r2_match_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ocMatch[0])) |-> flagQ[FLG_W-1]);

  a_r5_capture_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(capEvt[0])) |-> flagQ[NUM_IC-2]);

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(flagQ) & ~$past(clrNow) & ~flagQ) == '0));

  a_r3_pins_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(|ocMatch[NUM_OC-1:1])) |-> $stable(cmpPin));

  a_r4_shared_pin_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(selQ)) |-> cmpPin[NUM_PIN-1] == $past(cmpPin[NUM_PIN-1]));

  a_r8_irq_persists: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(irq) && !$past(ctlWrite)) |-> irq);
endmodule

bind octmr octmr_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .cntQ(cntQ), .ocMatch(ocMatch), .capEvt(capEvt), .flagQ(flagQ), .selQ(selQ),
  .cmpPin(cmpPin), .irq(irq)
);

// File: tb/sim_octmr.sv
`timescale 1ns/1ps
module sim_octmr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  capIn = '0;
  logic [3:0]  cmpPin;
  logic        irq;

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 0;
  string curReq = "R9";

  // behavioural reference state
  logic [15:0] mCnt;
  logic [15:0] mCmp [5];
  logic [15:0] mCap [4];
  logic [7:0]  mAct, mMask, mFlag;
  logic        mSel;
  logic [3:0]  mPin, mPrev;

  always #4 clk = ~clk;

  octmr u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
            .busWdata(busWdata), .busRdata(busRdata), .capIn(capIn),
            .cmpPin(cmpPin), .irq(irq));

  always @(posedge clk or negedge rstN) begin
    logic [4:0] m;
    logic [3:0] e;
    logic [7:0] ev, clr;
    if (!rstN) begin
      mCnt = 0; mAct = 0; mMask = 0; mFlag = 0; mSel = 0; mPin = 0; mPrev = 0;
      for (int i = 0; i < 5; i++) mCmp[i] = 16'hFFFF;
      for (int k = 0; k < 4; k++) mCap[k] = 0;
    end else begin
      for (int i = 0; i < 5; i++) m[i] = (mCnt == mCmp[i]) && !(i == 4 && mSel);
      for (int k = 0; k < 4; k++) e[k] = capIn[k] && !mPrev[k] && !(k == 3 && !mSel);
      ev  = {m[0], m[1], m[2], m[3], m[4] | e[3], e[0], e[1], e[2]};
      clr = (busWe && busAddr == 4'd12) ? busWdata[7:0] : 8'h00;
      mFlag = (mFlag & ~clr) | ev;
      for (int p = 0; p < 4; p++) begin
        if (m[p+1]) begin
          case (mAct[7-2*p -: 2])
            2'b01: mPin[p] = ~mPin[p];
            2'b10: mPin[p] = 1'b0;
            2'b11: mPin[p] = 1'b1;
            default: ;
          endcase
        end
      end
      for (int k = 0; k < 4; k++) if (e[k]) mCap[k] = mCnt;
      if (busWe) begin
        if (busAddr >= 4'd1 && busAddr <= 4'd5) mCmp[busAddr-1] = busWdata;
        if (busAddr == 4'd10) mAct  = busWdata[7:0];
        if (busAddr == 4'd11) mMask = busWdata[7:0];
        if (busAddr == 4'd13) mSel  = busWdata[0];
      end
      mPrev = capIn;
      mCnt  = mCnt + 16'd1;
    end
  end

  function automatic logic [15:0] mRead(input logic [3:0] a);
    if (a == 0) return mCnt;
    if (a >= 1 && a <= 5) return mCmp[a-1];
    if (a >= 6 && a <= 9) return mCap[a-6];
    if (a == 10) return {8'h00, mAct};
    if (a == 11) return {8'h00, mMask};
    if (a == 12) return {8'h00, mFlag};
    if (a == 13) return {15'h0, mSel};
    return 16'h0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(curReq, "rdata", busRdata, mRead(busAddr));
      chk(curReq, "pins", cmpPin, mPin);
      chk(curReq, "irq", irq, |(mFlag & mMask));
    end
  end

  task automatic step(input int a, input bit we, input int d);
    @(posedge clk); #1;
    busAddr = a[3:0]; busWe = we; busWdata = d[15:0];
  endtask
  task automatic idle(input int n, input int a);
    repeat (n) step(a, 0, 0);
  endtask
  task automatic pulse(input int k);
    @(posedge clk); #1; busWe = 0; capIn[k] = 1'b1;
    @(posedge clk); #1; capIn[k] = 1'b0;
  endtask

  initial begin
    logic [15:0] tgt;
    // R9: reset values across the whole map while reset is held
    curReq = "R9";
    for (int a = 0; a < 16; a++) begin
      @(posedge clk); #1; busAddr = a[3:0];
    end
    @(posedge clk); #1; rstN = 1'b1; busAddr = 0;
    // R1: counting and wrap past 16'hFFFF, write to counter ignored
    curReq = "R1";
    step(0, 1, 16'h1234);
    idle(65545, 0);
    // R10: unused address and read-only captures ignore writes
    curReq = "R10";
    step(7, 1, 16'hBEEF); idle(2, 7); idle(2, 14); idle(2, 15);
    // R2: compare flags without enables
    curReq = "R2";
    for (int i = 0; i < 4; i++) step(1 + i, 1, mCnt + 20 + i);
    idle(30, 12);
    // R7: partial clear, zero write, simultaneous set and clear
    curReq = "R7";
    step(12, 1, 16'h0050); idle(3, 12);
    step(12, 1, 16'h0000); idle(3, 12);
    step(12, 1, 16'h00FF); idle(2, 12);
    tgt = mCnt + 16'd8;
    step(1, 1, tgt);
    while (16'(mCnt + 16'd1) != tgt) step(12, 0, 0);
    step(12, 1, 16'h0080);
    idle(4, 12);
    // R3: action codes on each pin, twice with different codes
    curReq = "R3";
    step(12, 1, 16'h00FF);
    step(10, 1, 16'h006C);
    for (int i = 1; i < 5; i++) step(1 + i, 1, mCnt + 15);
    idle(20, 0);
    step(10, 1, 16'h00D9);
    for (int i = 1; i < 5; i++) step(1 + i, 1, mCnt + 15);
    idle(20, 0);
    for (int i = 1; i < 5; i++) step(1 + i, 1, mCnt + 12);
    idle(20, 12);
    // R4: shared slot in capture mode, then compare mode
    curReq = "R4";
    step(12, 1, 16'h00FF);
    step(13, 1, 1); step(10, 1, 16'h0001); step(5, 1, mCnt + 6);
    idle(10, 12);
    pulse(3); idle(3, 9); idle(2, 12);
    step(12, 1, 16'h00FF);
    step(13, 1, 0);
    pulse(3); idle(3, 9);
    step(5, 1, mCnt + 6); idle(10, 12);
    // R5: captures on the three plain inputs
    curReq = "R5";
    step(12, 1, 16'h00FF);
    pulse(0); idle(2, 6); idle(5, 12);
    pulse(1); idle(3, 7);
    pulse(2); idle(2, 8); idle(2, 12);
    @(posedge clk); #1; capIn[0] = 1'b1; idle(4, 6); capIn[0] = 1'b0; idle(2, 12);
    // R6: each enable bit alone against the flag layout
    curReq = "R6";
    for (int b = 0; b < 8; b++) begin
      step(11, 1, 1 << b); idle(2, 12);
    end
    // R8: irq rises with an enabled event and falls on clear or disable
    curReq = "R8";
    step(12, 1, 16'h00FF);
    step(11, 1, 16'h0084);
    step(1, 1, mCnt + 5); idle(8, 12);
    pulse(0); idle(3, 12);
    step(12, 1, 16'h0080); idle(2, 12);
    step(11, 1, 16'h0000); idle(2, 12);
    step(11, 1, 16'h0004); idle(2, 12);
    step(12, 1, 16'h0004); idle(3, 12);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog %s actual=hung expected=finished", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule